// File: doc/BRIEF.md
# Outstanding Cache Request Tracker

This block sits between a processor front end and a cache controller and keeps a record of every memory request that has been sent downstream but has not yet completed. Each request carries a byte address, a kind (load, instruction fetch, store or atomic read-modify-write) and a byte length. The tracker admits at most one pending request per cache line. It places loads and fetches in a read table and stores and atomics in a write table. Admitted requests pass straight through to the downstream issue port, tagged with a fresh identifier. When the cache controller signals a completion on the read or the write completion port, the matching entry is freed and its identifier is returned.

The front-end port and the downstream issue port use valid/ready. The block holds no request of its own. `iss_valid` rises in the same cycle as `req_valid` whenever the request is admissible, and `req_ready` is that admission gated by `iss_ready`. The transfer therefore completes on both ports at the same clock edge, and back-pressure from downstream stalls the front end directly. A refused request is not stored. The producer may keep it on the port until it is admitted, or withdraw it. The completion ports are plain strobes and are always taken.

A timeout watchdog runs only while work is pending. It samples the ages of all entries once per timeout period and raises a sticky deadlock flag if any entry has grown too old. A completion that matches nothing raises a sticky protocol-error flag.

Top module: `req_track`

## Requirements
- R1: A request is refused (`req_ready` low) while `out_cnt` equals MAX_OUT, and `out_cnt` never exceeds MAX_OUT.
- R2: A request is refused while its line (address bits above the line offset) is pending in either table, whatever the kinds of the two requests.
- R3: Kind encoding: 0 load, 1 fetch, 2 store, 3 atomic. Kinds 2 and 3 occupy the write table (WR_SLOTS entries) and kinds 0 and 1 occupy the read table (RD_SLOTS entries). A full table refuses only requests of its own class.
- R4: `out_cnt` rises by one on each accepted request and falls by one on each matched completion. It always equals the sum of the two table occupancies. `empty` is high exactly when both tables are empty.
- R5: The watchdog arms on an acceptance made while it is idle. Exactly THRESH cycles later it checks every entry, and any entry whose age (cycle counter minus issue stamp, modulo 2^TS_W) is at least THRESH sets the sticky `deadlock`. After a check it re-arms for another THRESH cycles if entries remain, and goes idle otherwise. An entry accepted 5 cycles after arming is therefore flagged at cycle 2*THRESH, not at cycle THRESH+5.
- R6: Accepted requests receive identifiers 0, 1, 2 and so on in order. The all-ones value is skipped, so the identifier after all-ones minus one is 0. `req_id` shows the identifier during an acceptance and all ones otherwise.
- R7: A request whose byte offset (address bits below the line size) plus `req_len` exceeds LINE_BYTES is refused.
- R8: `iss_valid` is high when a valid request is admissible, independent of `iss_ready`. `req_ready` also requires `iss_ready`. `iss_line`, `iss_kind` and `iss_id` carry the request's line, kind and identifier.
- R9: A completion frees the entry with that line in its own table, and its `*_done_id` shows that entry's identifier during the strobe. A completion that finds no such entry leaves the tables and `out_cnt` unchanged, shows all ones and sets the sticky `proto_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Front-end request valid |
| req_ready | output | 1 | Request admitted and downstream ready |
| req_addr | input | ADDR_W | Byte address |
| req_kind | input | 2 | 0 load, 1 fetch, 2 store, 3 atomic |
| req_len | input | OFF_W+1 | Byte length |
| req_id | output | ID_W | Identifier given, all ones when not accepted |
| iss_valid | output | 1 | Downstream issue valid |
| iss_ready | input | 1 | Downstream can take a request |
| iss_line | output | LINE_W | Line address issued |
| iss_kind | output | 2 | Kind issued |
| iss_id | output | ID_W | Identifier issued |
| rd_done_valid | input | 1 | Read completion strobe |
| rd_done_line | input | LINE_W | Line of the completed read |
| rd_done_id | output | ID_W | Identifier of the matched read entry |
| wr_done_valid | input | 1 | Write completion strobe |
| wr_done_line | input | LINE_W | Line of the completed write |
| wr_done_id | output | ID_W | Identifier of the matched write entry |
| out_cnt | output | CNT_W | Requests outstanding |
| empty | output | 1 | No request outstanding |
| deadlock | output | 1 | Sticky timeout flag |
| proto_err | output | 1 | Sticky unmatched-completion flag |

## Verification
The hardest case to reach is the phase between the watchdog's periodic check and an entry's issue time. An entry that is young at one check must stay unflagged until the next check, even after it has passed the threshold. The bench arms the watchdog with one request, adds a second request five cycles later and completes the first. It then shows the flag still low one cycle before twice the threshold and high at that cycle. The identifier skip is reached by admitting and completing more requests than the identifier space holds. The length rule is swept over every offset and length.

// File: rtl/req_track_pkg.sv
package req_track_pkg;
  localparam logic [1:0] KIND_LOAD   = 2'd0;
  localparam logic [1:0] KIND_FETCH  = 2'd1;
  localparam logic [1:0] KIND_STORE  = 2'd2;
  localparam logic [1:0] KIND_ATOMIC = 2'd3;

  // stores and atomics live in the write table
  function automatic logic is_write(input logic [1:0] kind);
    return kind[1];
  endfunction
endpackage

// File: rtl/req_table.sv
module req_table #(
  parameter int DEPTH  = 4,
  parameter int LINE_W = 8,
  parameter int ID_W   = 8,
  parameter int TS_W   = 10,
  parameter int THRESH = 256,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TS_W-1:0]   now,
  input  logic [LINE_W-1:0] look_line,
  output logic              look_hit,
  input  logic              alloc_en,
  input  logic [LINE_W-1:0] alloc_line,
  input  logic [ID_W-1:0]   alloc_id,
  output logic              full,
  input  logic              free_en,
  input  logic [LINE_W-1:0] free_line,
  output logic              free_hit,
  output logic [ID_W-1:0]   free_id,
  output logic [OCC_W-1:0]  occ,
  output logic              any_old
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]  vld;
  logic [LINE_W-1:0] e_line [DEPTH];
  logic [ID_W-1:0]   e_id   [DEPTH];
  logic [TS_W-1:0]   e_ts   [DEPTH];
  logic [DEPTH-1:0]  look_m, free_m, old_m;
  logic [IDX_W-1:0]  slot;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [TS_W-1:0] age;
    assign age       = now - e_ts[g];  // modulo arithmetic: wrap-safe
    assign look_m[g] = vld[g] && (e_line[g] == look_line);
    assign free_m[g] = vld[g] && (e_line[g] == free_line);
    assign old_m[g]  = vld[g] && (age >= TS_W'(THRESH));
  end

  always_comb begin
    logic found;
    found   = 1'b0;
    slot    = '0;
    free_id = '1;
    occ     = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!vld[i] && !found) begin
        slot  = IDX_W'(i);
        found = 1'b1;
      end
      if (free_m[i]) free_id = e_id[i];
      occ = occ + OCC_W'(vld[i]);
    end
  end

  assign look_hit = |look_m;
  assign free_hit = |free_m;
  assign full     = &vld;
  assign any_old  = |old_m;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
    end else begin
      if (free_en) begin
        for (int i = 0; i < DEPTH; i++)
          if (free_m[i]) vld[i] <= 1'b0;
      end
      if (alloc_en) begin
        vld[slot]    <= 1'b1;
        e_line[slot] <= alloc_line;
        e_id[slot]   <= alloc_id;
        e_ts[slot]   <= now;
      end
    end
  end
endmodule

// File: rtl/req_watchdog.sv
module req_watchdog #(
  parameter int THRESH = 256,
  localparam int CW = (THRESH > 1) ? $clog2(THRESH) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic insert,
  input  logic any_old,
  input  logic drain,
  output logic deadlock
);
  logic          armed;
  logic [CW-1:0] wait_cnt;
  logic          check;

  assign check = armed && (wait_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      wait_cnt <= '0;
      deadlock <= 1'b0;
    end else begin
      if (check) begin
        if (any_old) deadlock <= 1'b1;
        if (drain) armed <= 1'b0;
        else       wait_cnt <= CW'(THRESH - 1);
      end else if (armed) begin
        wait_cnt <= wait_cnt - 1'b1;
      end
      if (insert && !armed) begin
        armed    <= 1'b1;
        wait_cnt <= CW'(THRESH - 1);
      end
    end
  end
endmodule

// File: rtl/req_track.sv
module req_track #(
  parameter int ADDR_W     = 12,
  parameter int LINE_BYTES = 16,
  parameter int RD_SLOTS   = 4,
  parameter int WR_SLOTS   = 4,
  parameter int MAX_OUT    = 6,
  parameter int ID_W       = 8,
  parameter int TS_W       = 10,
  parameter int THRESH     = 256,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int LINE_W = ADDR_W - OFF_W,
  localparam int LEN_W  = OFF_W + 1,
  localparam int CNT_W  = $clog2(MAX_OUT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_kind,
  input  logic [LEN_W-1:0]  req_len,
  output logic [ID_W-1:0]   req_id,
  output logic              iss_valid,
  input  logic              iss_ready,
  output logic [LINE_W-1:0] iss_line,
  output logic [1:0]        iss_kind,
  output logic [ID_W-1:0]   iss_id,
  input  logic              rd_done_valid,
  input  logic [LINE_W-1:0] rd_done_line,
  output logic [ID_W-1:0]   rd_done_id,
  input  logic              wr_done_valid,
  input  logic [LINE_W-1:0] wr_done_line,
  output logic [ID_W-1:0]   wr_done_id,
  output logic [CNT_W-1:0]  out_cnt,
  output logic              empty,
  output logic              deadlock,
  output logic              proto_err
);
  import req_track_pkg::*;

  localparam int RD_OW = $clog2(RD_SLOTS + 1);
  localparam int WR_OW = $clog2(WR_SLOTS + 1);
  localparam logic [ID_W-1:0] ID_LAST = ~ID_W'(1);

  logic [TS_W-1:0]   now;
  logic [ID_W-1:0]   id_cur;
  logic [LINE_W-1:0] line;
  logic [OFF_W-1:0]  off;
  logic [LEN_W:0]    span_end;
  logic              span_ok, wr_kind, tgt_full, at_max, admit, accept;
  logic              rd_hit, wr_hit, rd_full, wr_full, rd_free_hit, wr_free_hit;
  logic              rd_old, wr_old, rd_dec, wr_dec;
  logic [RD_OW-1:0]  rd_occ;
  logic [WR_OW-1:0]  wr_occ;
  logic [CNT_W-1:0]  cnt_nxt;

  assign line     = req_addr[ADDR_W-1:OFF_W];
  assign off      = req_addr[OFF_W-1:0];
  assign span_end = (LEN_W+1)'(off) + (LEN_W+1)'(req_len);
  assign span_ok  = span_end <= (LEN_W+1)'(LINE_BYTES);
  assign wr_kind  = is_write(req_kind);
  assign tgt_full = wr_kind ? wr_full : rd_full;
  assign at_max   = out_cnt >= CNT_W'(MAX_OUT);
  assign admit    = !at_max && !rd_hit && !wr_hit && !tgt_full && span_ok;

  assign iss_valid = req_valid && admit;
  assign req_ready = admit && iss_ready;
  assign accept    = req_valid && req_ready;
  assign req_id    = accept ? id_cur : '1;
  assign iss_line  = line;
  assign iss_kind  = req_kind;
  assign iss_id    = id_cur;

  req_table #(
    .DEPTH(RD_SLOTS), .LINE_W(LINE_W), .ID_W(ID_W), .TS_W(TS_W), .THRESH(THRESH)
  ) u_rd_tab (
    .clk(clk), .rst_n(rst_n), .now(now),
    .look_line(line), .look_hit(rd_hit),
    .alloc_en(accept && !wr_kind), .alloc_line(line), .alloc_id(id_cur),
    .full(rd_full),
    .free_en(rd_done_valid), .free_line(rd_done_line),
    .free_hit(rd_free_hit), .free_id(rd_done_id),
    .occ(rd_occ), .any_old(rd_old)
  );

  req_table #(
    .DEPTH(WR_SLOTS), .LINE_W(LINE_W), .ID_W(ID_W), .TS_W(TS_W), .THRESH(THRESH)
  ) u_wr_tab (
    .clk(clk), .rst_n(rst_n), .now(now),
    .look_line(line), .look_hit(wr_hit),
    .alloc_en(accept && wr_kind), .alloc_line(line), .alloc_id(id_cur),
    .full(wr_full),
    .free_en(wr_done_valid), .free_line(wr_done_line),
    .free_hit(wr_free_hit), .free_id(wr_done_id),
    .occ(wr_occ), .any_old(wr_old)
  );

  assign rd_dec  = rd_done_valid && rd_free_hit;
  assign wr_dec  = wr_done_valid && wr_free_hit;
  assign cnt_nxt = out_cnt + CNT_W'(accept) - CNT_W'(rd_dec) - CNT_W'(wr_dec);
  assign empty   = (rd_occ == '0) && (wr_occ == '0);

  req_watchdog #(.THRESH(THRESH)) u_wd (
    .clk(clk), .rst_n(rst_n),
    .insert(accept), .any_old(rd_old || wr_old),
    .drain(cnt_nxt == '0), .deadlock(deadlock)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      now       <= '0;
      id_cur    <= '0;
      out_cnt   <= '0;
      proto_err <= 1'b0;
    end else begin
      now     <= now + 1'b1;
      out_cnt <= cnt_nxt;
      if (accept) id_cur <= (id_cur == ID_LAST) ? '0 : id_cur + 1'b1;
      if ((rd_done_valid && !rd_free_hit) || (wr_done_valid && !wr_free_hit))
        proto_err <= 1'b1;
    end
  end
endmodule

// File: rtl/req_track_chk.sv
module req_track_chk #(
  parameter int ADDR_W = 12,
  parameter int OFF_W  = 4,
  parameter int LEN_W  = 5,
  parameter int LINE_BYTES = 16,
  parameter int ID_W   = 8,
  parameter int CNT_W  = 3,
  parameter int MAX_OUT = 6,
  parameter int RD_OW  = 3,
  parameter int WR_OW  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [LEN_W-1:0]  req_len,
  input logic [ID_W-1:0]   req_id,
  input logic              iss_valid,
  input logic              iss_ready,
  input logic [CNT_W-1:0]  out_cnt,
  input logic              empty,
  input logic              deadlock,
  input logic              proto_err,
  input logic [RD_OW-1:0]  rd_occ,
  input logic [WR_OW-1:0]  wr_occ
);
  AST_CNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    out_cnt <= CNT_W'(MAX_OUT)); // R1
  AST_CNT_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    32'(out_cnt) == 32'(rd_occ) + 32'(wr_occ)); // R4
  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    empty == (out_cnt == '0)); // R4
  AST_DEADLOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    deadlock |=> deadlock); // R5
  AST_REFUSE_ID: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |-> (req_id == '1)); // R6
  AST_SPAN_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |->
      (32'(req_addr[OFF_W-1:0]) + 32'(req_len) <= LINE_BYTES)); // R7
  AST_ISSUE_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |-> (iss_valid && iss_ready)); // R8
  AST_PROTO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err); // R9
endmodule

bind req_track req_track_chk #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .LEN_W(LEN_W), .LINE_BYTES(LINE_BYTES),
  .ID_W(ID_W), .CNT_W(CNT_W), .MAX_OUT(MAX_OUT), .RD_OW(RD_OW), .WR_OW(WR_OW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_len(req_len), .req_id(req_id),
  .iss_valid(iss_valid), .iss_ready(iss_ready), .out_cnt(out_cnt),
  .empty(empty), .deadlock(deadlock), .proto_err(proto_err),
  .rd_occ(rd_occ), .wr_occ(wr_occ)
);

// File: tb/req_track_test.sv
`timescale 1ns/1ps
module req_track_test;
  localparam int TH = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, iss_ready = 1'b1;
  logic [11:0] req_addr = '0;
  logic [1:0]  req_kind = '0;
  logic [4:0]  req_len = '0;
  logic        req_ready, iss_valid, empty, deadlock, proto_err;
  logic [7:0]  req_id, iss_id, rd_done_id, wr_done_id, iss_line;
  logic [1:0]  iss_kind;
  logic        rd_done_valid = 1'b0, wr_done_valid = 1'b0;
  logic [7:0]  rd_done_line = '0, wr_done_line = '0;
  logic [2:0]  out_cnt;

  int nchk = 0, nerr = 0;

  always #2 clk = ~clk;

  req_track uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_kind(req_kind), .req_len(req_len), .req_id(req_id),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_line(iss_line),
    .iss_kind(iss_kind), .iss_id(iss_id),
    .rd_done_valid(rd_done_valid), .rd_done_line(rd_done_line), .rd_done_id(rd_done_id),
    .wr_done_valid(wr_done_valid), .wr_done_line(wr_done_line), .wr_done_id(wr_done_id),
    .out_cnt(out_cnt), .empty(empty), .deadlock(deadlock), .proto_err(proto_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // present a request for one cycle; sample combinational answers before the edge
  task automatic do_req(input int line, input int kind, input bit acc, input int id,
                        input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_addr = 12'(line << 4); req_kind = 2'(kind); req_len = 5'd4;
    #1;
    chk({tag, " ready"}, req_ready, acc);
    chk({tag, " id"}, req_id, acc ? id : 255);
    if (acc) begin
      chk({tag, " R8 iss_line"}, iss_line, line);
      chk({tag, " R8 iss_kind"}, iss_kind, kind);
      chk({tag, " R8 iss_id"}, iss_id, id);
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic done(input bit wr, input int line, input int id, input string tag);
    @(negedge clk);
    if (wr) begin wr_done_valid = 1'b1; wr_done_line = 8'(line); end
    else    begin rd_done_valid = 1'b1; rd_done_line = 8'(line); end
    #1;
    chk({tag, " done_id"}, wr ? wr_done_id : rd_done_id, id);
    @(posedge clk); #1;
    rd_done_valid = 1'b0; wr_done_valid = 1'b0;
  endtask

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
      end
    join_none

    do_reset();
    #1;
    chk("R4 reset out_cnt", out_cnt, 0);
    chk("R4 reset empty", empty, 1);
    chk("R5 reset deadlock", deadlock, 0);
    chk("R9 reset proto_err", proto_err, 0);

    // fill the read table with loads and fetches
    do_req(1, 0, 1, 0, "R3 load l1");
    do_req(2, 1, 1, 1, "R3 fetch l2");
    do_req(3, 0, 1, 2, "R3 load l3");
    do_req(4, 1, 1, 3, "R3 fetch l4");
    chk("R4 count after 4", out_cnt, 4);
    do_req(5, 0, 0, 0, "R3 read table full");
    do_req(10, 2, 1, 4, "R3 store l10");
    do_req(11, 3, 1, 5, "R3 atomic l11");
    chk("R4 count at max", out_cnt, 6);
    do_req(12, 2, 0, 0, "R1 refused at max");
    chk("R1 count held", out_cnt, 6);
    done(0, 1, 0, "R9 rd l1");
    chk("R4 count after done", out_cnt, 5);
    do_req(2, 2, 0, 0, "R2 store on pending read line");
    do_req(10, 0, 0, 0, "R2 load on pending write line");
    do_req(1, 2, 1, 6, "R3 store l1 after free");
    done(1, 10, 4, "R9 wr l10");

    // downstream back-pressure
    @(negedge clk);
    iss_ready = 1'b0; req_valid = 1'b1; req_addr = 12'h070; req_kind = 2'd0; req_len = 5'd1;
    #1;
    chk("R8 iss_valid under stall", iss_valid, 1);
    chk("R8 ready under stall", req_ready, 0);
    @(posedge clk); #1;
    req_valid = 1'b0; iss_ready = 1'b1;
    chk("R8 nothing taken under stall", out_cnt, 5);

    done(0, 2, 1, "R9 rd l2");
    done(0, 3, 2, "R9 rd l3");
    done(0, 4, 3, "R9 rd l4");
    done(1, 11, 5, "R9 wr l11");
    done(1, 1, 6, "R9 wr l1");
    chk("R4 drained count", out_cnt, 0);
    chk("R4 drained empty", empty, 1);

    // exhaustive offset/length sweep on an empty tracker
    do_reset();
    for (int o = 0; o < 16; o++) begin
      for (int l = 0; l <= 16; l++) begin
        @(negedge clk);
        req_valid = 1'b1; req_addr = 12'(9 * 16 + o); req_kind = 2'd0; req_len = 5'(l);
        #1;
        chk($sformatf("R7 off %0d len %0d", o, l), req_ready, (o + l <= 16) ? 1 : 0);
        req_valid = 1'b0;
      end
    end
    chk("R7 sweep left nothing", out_cnt, 0);

    // identifier sequence across the skipped all-ones value
    for (int i = 0; i < 260; i++) begin
      do_req(5, 0, 1, i % 255, "R6 id sequence");
      done(0, 5, i % 255, "R6 id return");
    end

    // completions that match nothing
    do_req(6, 0, 1, 260 % 255, "R9 load l6");
    done(1, 6, 255, "R9 write done on read line");
    chk("R9 proto_err set", proto_err, 1);
    chk("R9 count kept", out_cnt, 1);
    done(0, 6, 260 % 255, "R9 read done l6");
    chk("R9 count after real done", out_cnt, 0);
    chk("R9 proto_err sticky", proto_err, 1);

    // watchdog phase: A arms at E0, B enters at E5, A leaves at E10
    do_reset();
    do_req(20, 0, 1, 0, "R5 req A");
    repeat (4) @(posedge clk);
    do_req(21, 2, 1, 1, "R5 req B");
    repeat (4) @(posedge clk);
    done(0, 20, 0, "R5 done A");
    repeat (2 * TH - 11) @(posedge clk);
    #1;
    chk("R5 no deadlock before second check", deadlock, 0);
    @(posedge clk); #1;
    chk("R5 deadlock at second check", deadlock, 1);
    done(1, 21, 1, "R5 done B");
    chk("R5 deadlock sticky", deadlock, 1);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule